// File: doc/BRIEF.md
# Multi-Window I/O Address Decoder

This block turns a host I/O address into a chip select for one of several on-card functions. Each function owns a small set of configuration registers: a few base registers, one shared size mask and a two-bit control register. Host software writes these during configuration. A function can have several windows that do not touch each other, and all of them share the one size mask. Each window is aligned to its size, and the size is always a power of two.

When the host drives an I/O cycle, the block compares the address against every enabled window of every function. It raises, one clock later, a single select line and a hit flag. The size mask is kept as a contiguous run of ones from bit 0. Any value that is not such a run is repaired when it is written. If two functions claim the same address, the function with the lower index takes the cycle.

Top module: `iowin_decoder`

## Requirements
- R1: After reset every base, mask and control register reads zero, and `fn_sel` and `hit` are zero.
- R2: In the clock after a cycle with `io_strobe` high, `fn_sel[f]` is 1 when, for some implemented base of function f, the address equals that base on every bit where the mask is zero. This needs control bits [1:0] of function f to be 2'b11 (bit 0 enables the function, bit 1 enables its windows).
- R3: A write to the mask (`reg_sel` = 4) stores the written value with every bit below its highest set bit forced to one. A read of the mask therefore returns a run of ones from bit 0.
- R4: A function whose control bits [1:0] are not 2'b11 never asserts its select.
- R5: Each implemented base (`reg_sel` 0 to NUM_BASE-1) opens its own window, and a match on any one of them selects the function.
- R6: When several functions match, only the lowest-numbered one is selected, so `fn_sel` is zero or one-hot.
- R7: A base slot at or above NUM_BASE (and below 4) ignores writes, reads zero and never matches.
- R8: In the clock after a cycle with `io_strobe` low, `fn_sel` and `hit` are zero.
- R9: `hit` is 1 exactly when some bit of `fn_sel` is 1.
- R10: A register write takes effect from the next clock. A decode in the same cycle as a write uses the old value.
- R11: Register map for each function: `reg_sel` 0..3 are the bases, 4 is the mask and 5 is the control register, which reads back as bits [1:0] with zeros above. Other codes read zero, and writes to them do nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr | input | ADDR_W | Host I/O address |
| io_strobe | input | 1 | I/O cycle in progress |
| reg_we | input | 1 | Register write enable |
| reg_func | input | FW | Function whose registers are addressed |
| reg_sel | input | 3 | Register code inside the function |
| reg_wdata | input | ADDR_W | Write data |
| reg_rdata | output | ADDR_W | Read data for `reg_func`/`reg_sel` (combinational) |
| fn_sel | output | NUM_FUNC | Registered per-function select |
| hit | output | 1 | Registered any-function match |

## Verification
A register write and an address decode can fall in the same clock. The decode must then see the register contents from before the write. The bench provokes this by rewriting a base in the very cycle it strobes an address that only the old base covers. It expects the old select one clock later, then probes again and expects the new window to take over. The scoreboard queues the expected select and hit for each strobe, and compares them one cycle later.

// File: rtl/iowin_pkg.sv
package iowin_pkg;
   localparam int unsigned REG_CODE_W = 3;
   localparam int unsigned MAX_BASE   = 4;

   typedef enum logic [REG_CODE_W-1:0] {
      RC_BASE0 = 3'd0,
      RC_BASE1 = 3'd1,
      RC_BASE2 = 3'd2,
      RC_BASE3 = 3'd3,
      RC_MASK  = 3'd4,
      RC_CTRL  = 3'd5
   } reg_code_e;

   // Turn any value into a run of ones from bit 0 up to its highest set bit.
   function automatic logic [31:0] fill_down(input logic [31:0] v);
      logic [31:0] r;
      r = v;
      for (int i = 30; i >= 0; i--) r[i] = r[i] | r[i+1];
      return r;
   endfunction
endpackage

// File: rtl/iowin_func_regs.sv
module iowin_func_regs
   import iowin_pkg::*;
#(
   parameter int unsigned ADDR_W      = 16,
   parameter int unsigned NUM_BASE    = 3,
   parameter bit          LIMIT_FIXED = 1'b0,
   parameter logic [31:0] LIMIT_INIT  = 32'h0
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_en,
   input  logic [REG_CODE_W-1:0] sel,
   input  logic [ADDR_W-1:0]     wr_data,
   output logic [ADDR_W-1:0]     rd_data,
   input  logic [ADDR_W-1:0]     addr,
   output logic                  match
);
   localparam logic [ADDR_W-1:0] FIXED_MASK = ADDR_W'(fill_down(LIMIT_INIT));

   logic [ADDR_W-1:0] base_q [NUM_BASE];
   logic [ADDR_W-1:0] mask_q;
   logic [1:0]        ctrl_q;
   logic [NUM_BASE-1:0] win_hit;

   for (genvar b = 0; b < NUM_BASE; b++) begin : g_base
      always_ff @(posedge clk) begin
         if (!rst_n)                                base_q[b] <= '0;
         else if (wr_en && sel == REG_CODE_W'(b))   base_q[b] <= wr_data;
      end
      assign win_hit[b] = ((addr ^ base_q[b]) & ~mask_q) == '0;
   end

   if (LIMIT_FIXED) begin : g_mask_fixed
      assign mask_q = FIXED_MASK;
   end else begin : g_mask_reg
      always_ff @(posedge clk) begin
         if (!rst_n)                      mask_q <= '0;
         else if (wr_en && sel == RC_MASK) mask_q <= ADDR_W'(fill_down(32'(wr_data)));
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)                       ctrl_q <= '0;
      else if (wr_en && sel == RC_CTRL) ctrl_q <= wr_data[1:0];
   end

   assign match = (ctrl_q == 2'b11) && (|win_hit);

   always_comb begin
      rd_data = '0;
      if (sel == RC_MASK)                     rd_data = mask_q;
      else if (sel == RC_CTRL)                rd_data = ADDR_W'(ctrl_q);
      else begin
         for (int b = 0; b < NUM_BASE; b++)
            if (sel == REG_CODE_W'(b)) rd_data = base_q[b];
      end
   end
endmodule

// File: rtl/iowin_prio.sv
module iowin_prio #(
   parameter int unsigned N = 2
) (
   input  logic [N-1:0] req,
   output logic [N-1:0] gnt
);
   always_comb begin
      gnt = '0;
      for (int i = N - 1; i >= 0; i--)
         if (req[i]) gnt = N'(1) << i;
   end
endmodule

// File: rtl/iowin_decoder.sv
module iowin_decoder
   import iowin_pkg::*;
#(
   parameter int unsigned ADDR_W      = 16,
   parameter int unsigned NUM_FUNC    = 2,
   parameter int unsigned NUM_BASE    = 3,
   parameter bit          LIMIT_FIXED = 1'b0,
   parameter logic [31:0] LIMIT_INIT  = 32'h0,
   localparam int unsigned FW = (NUM_FUNC > 1) ? $clog2(NUM_FUNC) : 1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [ADDR_W-1:0]     io_addr,
   input  logic                  io_strobe,
   input  logic                  reg_we,
   input  logic [FW-1:0]         reg_func,
   input  logic [2:0]            reg_sel,
   input  logic [ADDR_W-1:0]     reg_wdata,
   output logic [ADDR_W-1:0]     reg_rdata,
   output logic [NUM_FUNC-1:0]   fn_sel,
   output logic                  hit
);
   if (NUM_BASE < 1 || NUM_BASE > MAX_BASE) begin : g_bad_base
      $error("NUM_BASE must lie in 1..4");
   end
   if (ADDR_W < 1 || ADDR_W > 32) begin : g_bad_width
      $error("ADDR_W must lie in 1..32");
   end
   if (NUM_FUNC < 1) begin : g_bad_func
      $error("NUM_FUNC must be at least 1");
   end

   logic [NUM_FUNC-1:0] match;
   logic [NUM_FUNC-1:0] winner;
   logic [ADDR_W-1:0]   rd_vec [NUM_FUNC];

   for (genvar f = 0; f < NUM_FUNC; f++) begin : g_func
      iowin_func_regs #(
         .ADDR_W(ADDR_W), .NUM_BASE(NUM_BASE),
         .LIMIT_FIXED(LIMIT_FIXED), .LIMIT_INIT(LIMIT_INIT)
      ) u_regs (
         .clk     (clk),
         .rst_n   (rst_n),
         .wr_en   (reg_we && (32'(reg_func) == f)),
         .sel     (reg_sel),
         .wr_data (reg_wdata),
         .rd_data (rd_vec[f]),
         .addr    (io_addr),
         .match   (match[f])
      );
   end

   iowin_prio #(.N(NUM_FUNC)) u_prio (.req(match), .gnt(winner));

   always_comb begin
      reg_rdata = '0;
      for (int f = 0; f < NUM_FUNC; f++)
         if (32'(reg_func) == f) reg_rdata = rd_vec[f];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fn_sel <= '0;
         hit    <= 1'b0;
      end else begin
         fn_sel <= io_strobe ? winner : '0;
         hit    <= io_strobe && (|match);
      end
   end
endmodule

// File: rtl/iowin_decoder_chk.sv
module iowin_decoder_chk #(
   parameter int unsigned ADDR_W   = 16,
   parameter int unsigned NUM_FUNC = 2,
   parameter int unsigned NUM_BASE = 3,
   parameter int unsigned FW       = 1
) (
   input logic                clk,
   input logic                rst_n,
   input logic                io_strobe,
   input logic [FW-1:0]       reg_func,
   input logic [2:0]          reg_sel,
   input logic [ADDR_W-1:0]   reg_rdata,
   input logic [NUM_FUNC-1:0] fn_sel,
   input logic                hit
);
   p_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(fn_sel));

   p_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(io_strobe) |-> (fn_sel == '0 && !hit));

   p_hit_r9: assert property (@(posedge clk) disable iff (!rst_n)
      hit == (|fn_sel));

   p_mask_run_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_sel == 3'd4) |-> ((reg_rdata & ADDR_W'(reg_rdata + 1'b1)) == '0));

   p_unimpl_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (32'(reg_sel) >= NUM_BASE && reg_sel < 3'd4) |-> reg_rdata == '0);

   p_ctrl_width_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_sel == 3'd5) |-> (reg_rdata >> 2) == '0);
endmodule

bind iowin_decoder iowin_decoder_chk #(
   .ADDR_W(ADDR_W), .NUM_FUNC(NUM_FUNC), .NUM_BASE(NUM_BASE), .FW(FW)
) u_chk (
   .clk(clk), .rst_n(rst_n), .io_strobe(io_strobe), .reg_func(reg_func),
   .reg_sel(reg_sel), .reg_rdata(reg_rdata), .fn_sel(fn_sel), .hit(hit)
);

// File: tb/iowin_decoder_tb.sv
module iowin_decoder_tb;
   localparam int CLK_PERIOD = 10;
   localparam int AW = 16;
   localparam int NF = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] io_addr = '0;
   logic          io_strobe = 1'b0;
   logic          reg_we = 1'b0;
   logic [0:0]    reg_func = '0;
   logic [2:0]    reg_sel = '0;
   logic [AW-1:0] reg_wdata = '0;
   logic [AW-1:0] reg_rdata;
   logic [NF-1:0] fn_sel;
   logic          hit;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;
   logic strobe_d = 1'b0;

   typedef struct { logic [NF-1:0] sel; string tag; } exp_t;
   exp_t sb[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   iowin_decoder #(.ADDR_W(AW), .NUM_FUNC(NF), .NUM_BASE(3)) u_dut (
      .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_strobe(io_strobe),
      .reg_we(reg_we), .reg_func(reg_func), .reg_sel(reg_sel),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .fn_sel(fn_sel), .hit(hit)
   );

   always @(posedge clk) strobe_d <= io_strobe;

   task automatic check(input bit ok, input string tag, input logic [31:0] act,
                        input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // Monitor: pops one expected item per strobed cycle.
   always @(negedge clk) begin
      if (rst_n && strobe_d) begin
         if (sb.size() == 0) check(1'b0, "scoreboard underflow", 0, 1);
         else begin
            exp_t e;
            e = sb.pop_front();
            check(fn_sel == e.sel, {e.tag, " fn_sel"}, 32'(fn_sel), 32'(e.sel));
            check(hit == (|e.sel), "R9 hit", 32'(hit), 32'(|e.sel));
         end
      end
   end

   task automatic wr(input int f, input int s, input logic [AW-1:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_func = 1'(f); reg_sel = 3'(s); reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(input int f, input int s, input logic [AW-1:0] exp,
                     input string tag);
      @(negedge clk);
      reg_func = 1'(f); reg_sel = 3'(s);
      #1;
      check(reg_rdata == exp, tag, 32'(reg_rdata), 32'(exp));
   endtask

   task automatic probe(input logic [AW-1:0] a, input logic [NF-1:0] exp,
                        input string tag);
      exp_t e;
      @(negedge clk);
      io_addr = a; io_strobe = 1'b1;
      e.sel = exp; e.tag = tag;
      sb.push_back(e);
      @(negedge clk);
      io_strobe = 1'b0;
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      if (!done) begin
         fails++; checks++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      #1;
      check(fn_sel == '0 && !hit, "R1 outputs", {fn_sel, hit}, 0);
      for (int f = 0; f < NF; f++)
         for (int s = 0; s < 6; s++) rd(f, s, '0, "R1 register reset");

      probe(16'h0000, 2'b00, "R4 disabled after reset");

      // Function 0 setup
      wr(0, 0, 16'h03F8);
      wr(0, 4, 16'h0005);
      rd(0, 4, 16'h0007, "R3 mask fill 0x5");
      wr(0, 2, 16'h6000);
      probe(16'h03F8, 2'b00, "R4 ctrl still zero");
      wr(0, 5, 16'hFFFF);
      rd(0, 5, 16'h0003, "R11 ctrl readback");
      probe(16'h03F8, 2'b01, "R2 low edge");
      probe(16'h03FF, 2'b01, "R2 high edge");
      probe(16'h0400, 2'b00, "R2 above window");
      probe(16'h03F7, 2'b00, "R2 below window");

      // R5 second window
      wr(0, 1, 16'h8000);
      probe(16'h8003, 2'b01, "R5 base1 window");
      probe(16'h6007, 2'b01, "R5 base2 window");
      probe(16'h8008, 2'b00, "R5 past base1 window");

      // R7 unimplemented slot
      wr(0, 3, 16'h1234);
      rd(0, 3, 16'h0000, "R7 unimplemented read");
      probe(16'h1234, 2'b00, "R7 unimplemented no match");

      // Function 1 overlapping
      wr(1, 0, 16'h03F8);
      wr(1, 4, 16'h0009);
      rd(1, 4, 16'h000F, "R3 mask fill 0x9");
      wr(1, 5, 16'h0003);
      probe(16'h03F9, 2'b01, "R6 overlap lower wins");
      probe(16'h03F2, 2'b10, "R2 function1 window");

      // R4 partial control
      wr(0, 5, 16'h0002);
      probe(16'h03F9, 2'b10, "R4 ctrl=2 fn0 off");
      wr(0, 5, 16'h0001);
      probe(16'h03F9, 2'b10, "R4 ctrl=1 fn0 off");

      // R8 no strobe
      @(negedge clk);
      io_addr = 16'h03F2;
      @(negedge clk);
      @(negedge clk);
      check(fn_sel == '0 && !hit, "R8 no strobe", {fn_sel, hit}, 0);

      // R10 write and decode in same cycle
      begin
         exp_t e;
         @(negedge clk);
         io_addr = 16'h03F2; io_strobe = 1'b1;
         reg_we = 1'b1; reg_func = 1'b1; reg_sel = 3'd0; reg_wdata = 16'h5000;
         e.sel = 2'b10; e.tag = "R10 old base used";
         sb.push_back(e);
         @(negedge clk);
         io_strobe = 1'b0; reg_we = 1'b0;
      end
      probe(16'h03F2, 2'b00, "R10 new base in force");
      probe(16'h5005, 2'b10, "R10 new window");

      // R11 map corners
      rd(1, 6, 16'h0000, "R11 unused code");
      wr(1, 7, 16'hFFFF);
      rd(1, 0, 16'h5000, "R11 unused write no effect");
      wr(1, 4, 16'h0100);
      rd(1, 4, 16'h01FF, "R3 mask fill 0x100");

      repeat (3) @(negedge clk);
      check(sb.size() == 0, "scoreboard drained", sb.size(), 0);
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule